// File: doc/BRIEF.md
# Phase Comparator with Lock Indicator

This block is the phase-frequency comparator of a frequency synthesizer loop. It runs in a system clock domain and receives two single-cycle pulses: one from the divided reference and one from the divided oscillator. A reference pulse raises an up command and an oscillator pulse raises a down command. Once both commands are high, both are cleared together. The two commands leave the block as plain phase outputs for an external charge pump. They are also mapped onto a drive-enable and drive-value pair, which stands in for an on-chip tri-state pump.

A level-type lock flag watches the width of the phase error in each comparison period. It rises after a run of good periods, and a single bad period clears it. A power-enable input gates the whole block. When it is low, the block stops comparing, releases the pump, which opens the loop, and pulls the control flag low. When it rises, the block raises a one-cycle restart strobe so that both external dividers start again on the same clock. Comparison begins on the next cycle, so the first edges arrive aligned.

Top module: `pfd_lock_top`

## Requirements
- R1: A reference pulse sampled while running sets `pump_up` on the following edge, and an oscillator pulse sets `pump_dn` the same way. A command stays high until both are high. Both then read high for exactly one cycle and clear on the next edge unless a new pulse arrives.
- R2: `pump_up` and `pump_dn` present the two detector commands directly and are 0 while stopped.
- R3: `cp_drive_en` is 1 exactly when the block is running and one of `pump_up`/`pump_dn` is high. `cp_drive_val` is 1 while up is the active command and 0 while down is.
- R4: An edge that samples `pwr_en` low clears `pump_up`, `pump_dn` and `cp_drive_en`. While `pwr_en` is low, pulses on `ref_pulse` and `vco_pulse` have no effect.
- R5: `cp_ctrl` is 0 from reset and for every cycle after an edge that samples `pwr_en` low. It is 1 after an edge that samples `pwr_en` high.
- R6: `div_restart` is 1 during the single cycle in which `pwr_en` is high and `cp_ctrl` is still 0. Pulses in that cycle are ignored.
- R7: The phase error of a period is the number of clock edges that sample exactly one command high. A period ends on the edge that sees both high. `lock` rises on the edge that ends the LOCK_PERIODS-th (default 8) consecutive period whose error is below LOCK_TOL (default 4) edges.
- R8: A period whose error is LOCK_TOL or more clears `lock` and the run count on the edge that ends it.
- R9: An edge that samples `pwr_en` low clears `lock` and the run count, so a new run of LOCK_PERIODS good periods is needed after restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_en | input | 1 | 1 = operate, 0 = power save |
| ref_pulse | input | 1 | Single-cycle pulse from the reference divider |
| vco_pulse | input | 1 | Single-cycle pulse from the oscillator divider |
| div_restart | output | 1 | One-cycle strobe to restart both dividers together |
| cp_ctrl | output | 1 | Charge-pump control flag, 0 while divider operation is stopped |
| pump_up | output | 1 | Up command for an external pump |
| pump_dn | output | 1 | Down command for an external pump |
| cp_drive_en | output | 1 | Internal pump drive enable (0 = high impedance) |
| cp_drive_val | output | 1 | Internal pump drive value when enabled |
| lock | output | 1 | 1 = loop locked |

## Verification
The bench sweeps the offset between the two pulses from zero to past the tolerance, in both orders. Each sweep checks the one-cycle overlap, the clear, and the tri-state mapping. A detector that cleared early, or a pump that drove during the overlap, would fail here. Lock runs are tested at their edges: the seventh and eighth good periods, an error of exactly LOCK_TOL, and relock after a bad period. An off-by-one count or a `<=` tolerance would move lock by a period. Power save is dropped in the middle of a period, with pulses applied while off and in the restart cycle. A design that kept its state, counted those pulses or kept its lock credit would be caught.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_cmd_t;

endpackage

// File: rtl/pfd_pwr_seq.sv
module pfd_pwr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  output logic run,
  output logic active,
  output logic div_restart
);

  logic run_q;
  logic run_d;

  always_comb begin
    run_d = pwr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign run         = run_q;
  assign active      = pwr_en & run_q;
  assign div_restart = pwr_en & ~run_q;

  // Restart strobe is followed by a running cycle
  assert_restart_then_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_restart |=> run);

  // Stopped dividers keep the control flag low
  assert_ctrl_low_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !run);

endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  logic      ref_pulse,
  input  logic      vco_pulse,
  output pump_cmd_t cmd,
  output logic      period_end
);

  logic up_q, dn_q;
  logic up_d, dn_d;
  logic both;

  assign both = up_q & dn_q;

  always_comb begin
    up_d = 1'b0;
    dn_d = 1'b0;
    if (active) begin
      up_d = ref_pulse | (up_q & ~both);
      dn_d = vco_pulse | (dn_q & ~both);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign cmd.up     = up_q;
  assign cmd.dn     = dn_q;
  assign period_end = both;

  assert_ref_sets_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ref_pulse) |=> up_q);

  assert_vco_sets_dn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && vco_pulse) |=> dn_q);

  assert_both_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && !ref_pulse && !vco_pulse) |=> (!up_q && !dn_q));

endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect
  import pfd_lock_pkg::*;
#(
  parameter int LOCK_TOL     = 4,
  parameter int LOCK_PERIODS = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  pump_cmd_t cmd,
  input  logic      period_end,
  output logic      lock
);

  localparam int EW = $clog2(LOCK_TOL + 1);
  localparam int GW = $clog2(LOCK_PERIODS + 1);
  localparam logic [EW-1:0] TOL_V = EW'(LOCK_TOL);
  localparam logic [GW-1:0] RUN_V = GW'(LOCK_PERIODS);

  logic [EW-1:0] err_q, err_d;
  logic [GW-1:0] good_q, good_d;
  logic          err_ok;

  assign err_ok = (err_q < TOL_V);

  always_comb begin
    err_d  = err_q;
    good_d = good_q;
    if (!active) begin
      err_d  = '0;
      good_d = '0;
    end else if (period_end) begin
      err_d = '0;
      if (!err_ok)              good_d = '0;
      else if (good_q != RUN_V) good_d = good_q + 1'b1;
    end else if ((cmd.up ^ cmd.dn) && (err_q != TOL_V)) begin
      err_d = err_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
    end else begin
      err_q  <= err_d;
      good_q <= good_d;
    end
  end

  assign lock = (good_q == RUN_V);

  assert_lock_rise_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(period_end));

  assert_bad_period_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && period_end && !err_ok) |=> !lock);

  assert_save_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !lock);

endmodule

// File: rtl/pfd_pump_drive.sv
module pfd_pump_drive
  import pfd_lock_pkg::*;
(
  input  logic      run,
  input  pump_cmd_t cmd,
  output logic      pump_up,
  output logic      pump_dn,
  output logic      drive_en,
  output logic      drive_val
);

  always_comb begin
    pump_up   = cmd.up;
    pump_dn   = cmd.dn;
    drive_en  = run & (cmd.up ^ cmd.dn);
    drive_val = cmd.up & ~cmd.dn;
  end

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_lock_pkg::*;
#(
  parameter int LOCK_TOL     = 4,
  parameter int LOCK_PERIODS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  input  logic ref_pulse,
  input  logic vco_pulse,
  output logic div_restart,
  output logic cp_ctrl,
  output logic pump_up,
  output logic pump_dn,
  output logic cp_drive_en,
  output logic cp_drive_val,
  output logic lock
);

  logic      rst_meta_q, rst_sync_q;
  logic      run, active, period_end;
  pump_cmd_t cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pfd_pwr_seq u_pwr (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .pwr_en      (pwr_en),
    .run         (run),
    .active      (active),
    .div_restart (div_restart)
  );

  pfd_core u_core (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .active     (active),
    .ref_pulse  (ref_pulse),
    .vco_pulse  (vco_pulse),
    .cmd        (cmd),
    .period_end (period_end)
  );

  pfd_lock_detect #(
    .LOCK_TOL     (LOCK_TOL),
    .LOCK_PERIODS (LOCK_PERIODS)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .active     (active),
    .cmd        (cmd),
    .period_end (period_end),
    .lock       (lock)
  );

  pfd_pump_drive u_drive (
    .run       (run),
    .cmd       (cmd),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .drive_en  (cp_drive_en),
    .drive_val (cp_drive_val)
  );

  assign cp_ctrl = run;

  assert_drive_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cp_drive_en |-> (pump_up != pump_dn));

  assert_save_releases_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !pwr_en |=> (!pump_up && !pump_dn && !cp_drive_en));

  assert_hiz_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !cp_ctrl |-> !cp_drive_en);

endmodule

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;

  localparam int TOL  = 4;
  localparam int RUNS = 8;

  logic clk = 1'b0;
  logic rst_n, pwr_en, ref_pulse, vco_pulse;
  logic div_restart, cp_ctrl, pump_up, pump_dn, cp_drive_en, cp_drive_val, lock;

  int n_tests = 0;
  int n_fail  = 0;
  int gcnt    = 0;

  always #10 clk = ~clk;

  pfd_lock_top #(.LOCK_TOL(TOL), .LOCK_PERIODS(RUNS)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en),
    .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
    .div_restart(div_restart), .cp_ctrl(cp_ctrl),
    .pump_up(pump_up), .pump_dn(pump_dn),
    .cp_drive_en(cp_drive_en), .cp_drive_val(cp_drive_val), .lock(lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // One comparison period: leading pulse, then trailing pulse k edges later.
  task automatic period(input int k, input bit ref_first);
    @(negedge clk);
    ref_pulse = ref_first | (k == 0);
    vco_pulse = !ref_first | (k == 0);
    @(negedge clk);
    ref_pulse = 1'b0;
    vco_pulse = 1'b0;
    if (k > 0) begin
      chk("R1 lead cmd", ref_first ? pump_up : pump_dn, 1);
      chk("R2 trail cmd low", ref_first ? pump_dn : pump_up, 0);
      chk("R3 drive_en", cp_drive_en, 1);
      chk("R3 drive_val", cp_drive_val, ref_first ? 1 : 0);
      for (int i = 1; i < k; i++) @(negedge clk);
      if (ref_first) vco_pulse = 1'b1; else ref_pulse = 1'b1;
      @(negedge clk);
      ref_pulse = 1'b0;
      vco_pulse = 1'b0;
    end
    chk("R1 overlap up", pump_up, 1);
    chk("R1 overlap dn", pump_dn, 1);
    chk("R3 no drive in overlap", cp_drive_en, 0);
    if (k < TOL) gcnt = (gcnt < RUNS) ? gcnt + 1 : RUNS;
    else         gcnt = 0;
    @(negedge clk);
    chk("R1 clear up", pump_up, 0);
    chk("R1 clear dn", pump_dn, 0);
    chk((k < TOL) ? "R7 lock" : "R8 lock", lock, (gcnt == RUNS) ? 1 : 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("[TB] FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; pwr_en = 1'b0; ref_pulse = 1'b0; vco_pulse = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 reset ctrl", cp_ctrl, 0);
    chk("R2 reset up", pump_up, 0);
    chk("R7 reset lock", lock, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: pulses while in power save do nothing
    ref_pulse = 1'b1;
    @(negedge clk);
    ref_pulse = 1'b0;
    chk("R4 ignored while off", pump_up, 0);
    chk("R5 ctrl off", cp_ctrl, 0);

    // R6: restart strobe, pulse in restart cycle ignored
    pwr_en = 1'b1; ref_pulse = 1'b1;
    #1;
    chk("R6 restart strobe", div_restart, 1);
    chk("R5 ctrl still low", cp_ctrl, 0);
    @(negedge clk);
    ref_pulse = 1'b0;
    chk("R6 strobe one cycle", div_restart, 0);
    chk("R6 restart pulse ignored", pump_up, 0);
    chk("R5 ctrl on", cp_ctrl, 1);
    gcnt = 0;

    // Sweep offsets and orders
    for (int k = 0; k <= 6; k++) begin
      period(k, 1'b1);
      period(k, 1'b0);
    end

    // Lock run: 8 good periods, lock on the 8th
    for (int i = 0; i < RUNS; i++) period(i % TOL, i[0]);
    chk("R7 locked after run", lock, 1);
    period(TOL, 1'b1);
    chk("R8 unlocked by bad period", lock, 0);
    for (int i = 0; i < RUNS; i++) period(TOL - 1, 1'b0);
    chk("R7 relocked", lock, 1);

    // R4/R9: drop power mid-period
    @(negedge clk);
    ref_pulse = 1'b1;
    @(negedge clk);
    ref_pulse = 1'b0;
    chk("R1 up set", pump_up, 1);
    pwr_en = 1'b0;
    @(negedge clk);
    chk("R4 up cleared", pump_up, 0);
    chk("R4 drive released", cp_drive_en, 0);
    chk("R5 ctrl low", cp_ctrl, 0);
    chk("R9 lock cleared", lock, 0);
    vco_pulse = 1'b1; ref_pulse = 1'b1;
    @(negedge clk);
    vco_pulse = 1'b0; ref_pulse = 1'b0;
    chk("R4 dn ignored", pump_dn, 0);
    chk("R4 up ignored", pump_up, 0);
    chk("R6 no strobe while off", div_restart, 0);
    pwr_en = 1'b1;
    @(negedge clk);
    gcnt = 0;
    for (int i = 0; i < RUNS - 1; i++) period(1, 1'b1);
    chk("R9 no lock after 7", lock, 0);
    period(0, 1'b1);
    chk("R9 lock after 8", lock, 1);

    summary();
  end

endmodule